// File: doc/BRIEF.md
# SPI Flash User-Mode Command Controller

This block holds the per-chip-select control state of a serial flash controller. It also turns accesses on a memory-style data port into raw byte exchanges on a simple byte-shift engine. Software configures the block through a 32-bit register port. Each chip select has a control word that holds an access mode, an opcode byte and a chip-select drive bit. The drive bit goes straight to that select line, so software frames flash commands itself: it drives the select low, pushes bytes through the data port, then raises the select again.

The data port only carries traffic for a chip select whose mode field is set to user mode. A read of 1 to 4 bytes clocks out zero bytes and gathers the replies. A write of 1 to 4 bytes sends its bytes in order, least significant first. A write is carried out only when the configuration word has write permission set for the addressed chip select. Accesses in any other mode are completed at once without touching the byte engine. The port raises `dp_ready` for one cycle when the access is finished, after the last byte exchange where there is one.

Top module: `spi_user_ctrl`

## Requirements
- R1: After reset the following values hold:
  - `cs_n` is all ones.
  - Every chip-select control word reads 0x00000004.
  - The status word reads 0x00000800, which means DMA done.
  - With the default strap, the configuration word reads 0x00000002 (chip select 0 typed as serial flash, type code 2 in bits [1:0]) and the address-mode word reads 0x00000001 (chip select 0 uses 4-byte addresses).
- R2: The register map uses aligned byte addresses. The configuration word is at 0x00 and the address-mode word at 0x04. Chip-select control word k is at 0x20+4k. A write to any of these stores all 32 bits, and a combinational read on `reg_rdata` returns the stored value. This includes the opcode field [23:16] of a control word.
- R3: A read of an unmapped or unaligned address returns zero, and a write to it changes nothing. The status word at 0x08 is read-only.
- R4: `cs_n[k]` equals bit 2 of control word k; 1 deselects the flash. It changes only in the cycle after a register write.
- R5: Bits [1:0] of control word k give the mode of chip select k: 0 normal read, 1 fast read, 2 write, 3 user. The data port decodes this field for the chip select addressed by `dp_cs`.
- R6: A user-mode data-port read with `dp_size` = N-1 performs exactly N byte exchanges, each sending 0x00. The i-th received byte is returned in `dp_rdata[8i+7:8i]`, and the bytes above N are zero.
- R7: A user-mode data-port write with `dp_size` = N-1 performs N exchanges that send `dp_wdata` bytes 0, 1, … N-1 in that order.
- R8: A data-port write to chip select k is dropped, with no exchange, when configuration bit 16+k is clear. Reads are not gated by this bit.
- R9: In any mode other than user, a data-port read returns 0xFFFFFFFF and a write is dropped. Neither starts an exchange.
- R10: `sb_start` is a one-cycle pulse. It is never raised while `sb_busy` is high. The next exchange starts only after `sb_done` ends the previous one.
- R11: `dp_ready` is a one-cycle pulse that ends each accepted access. For a user-mode access it comes after the last exchange has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write when high, read when low |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| dp_req | input | 1 | Data-port request, held until dp_ready |
| dp_we | input | 1 | Data-port write when high |
| dp_cs | input | CSW | Addressed chip select |
| dp_size | input | 2 | Byte count minus one |
| dp_wdata | input | 32 | Data-port write data |
| dp_rdata | output | 32 | Data-port read data, valid with dp_ready |
| dp_ready | output | 1 | Access complete pulse |
| sb_start | output | 1 | Start one byte exchange |
| sb_tx | output | 8 | Byte to send |
| sb_busy | input | 1 | Byte engine busy |
| sb_done | input | 1 | Byte exchange finished |
| sb_rx | input | 8 | Received byte, valid with sb_done |
| cs_n | output | NUM_CS | Chip-select lines |

## Verification
The properties rely on three things about the inputs:
- `sb_done` pulses only once per exchange, and only after a start.
- A requester keeps `dp_req` and its fields steady until `dp_ready`, then drops `dp_req` in the next cycle.
- The byte engine raises `sb_busy` only while it is serving an exchange.

The bench's byte-engine model follows these rules. It raises busy in the cycle after it sees a start, holds it for two cycles, and ends with a single done pulse that carries a reply from a known rolling sequence. Every data-port transfer waits for `dp_ready` before the request is withdrawn.

// File: rtl/spi_uc_pkg.sv
package spi_uc_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NB = DW / 8;
  localparam int unsigned IW = $clog2(NB);

  localparam logic [7:0] A_CFG   = 8'h00;
  localparam logic [7:0] A_AMODE = 8'h04;
  localparam logic [7:0] A_STAT  = 8'h08;
  localparam logic [7:0] A_CTRL0 = 8'h20;

  localparam int unsigned F_CE       = 2;
  localparam int unsigned F_WEN0     = 16;
  localparam int unsigned F_DMA_DONE = 11;
  localparam logic [1:0]  MODE_USER  = 2'd3;
  localparam logic [1:0]  TYPE_SERIAL = 2'd2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} sq_state_e;

  // byte i of a word, least significant byte is index 0
  function automatic logic [7:0] byte_of(input logic [DW-1:0] w, input logic [IW-1:0] i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [DW-1:0] byte_put(input logic [DW-1:0] w, input logic [IW-1:0] i,
                                             input logic [7:0] b);
    logic [DW-1:0] r;
    r = w;
    r[8*i +: 8] = b;
    return r;
  endfunction

  function automatic logic [IW:0] count_of(input logic [IW-1:0] sz);
    return {1'b0, sz} + 1'b1;
  endfunction

  function automatic logic [7:0] ctrl_addr(input int unsigned k);
    return A_CTRL0 + 8'(4 * k);
  endfunction
endpackage

// File: rtl/spi_uc_regs.sv
module spi_uc_regs
  import spi_uc_pkg::*;
#(
  parameter int unsigned NUM_CS    = 4,
  parameter bit          STRAP_CS0 = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_req,
  input  logic                   reg_we,
  input  logic [7:0]             reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  output logic [NUM_CS-1:0][1:0] mode_vec,
  output logic [NUM_CS-1:0]      ce_vec,
  output logic [NUM_CS-1:0]      wen_vec
);
  localparam logic [DW-1:0] CFG_RST   = STRAP_CS0 ? DW'(TYPE_SERIAL) : '0;
  localparam logic [DW-1:0] AMODE_RST = STRAP_CS0 ? DW'(1) : '0;
  localparam logic [DW-1:0] CTRL_RST  = DW'(1) << F_CE;
  localparam logic [DW-1:0] STAT_VAL  = DW'(1) << F_DMA_DONE;

  logic            wr;
  logic [DW-1:0]   cfg_q;
  logic [DW-1:0]   amode_q;
  logic [DW-1:0]   ctrl_q [NUM_CS];

  assign wr = reg_req & reg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      amode_q <= AMODE_RST;
    end else if (wr) begin
      if (reg_addr == A_CFG)   cfg_q   <= reg_wdata;
      if (reg_addr == A_AMODE) amode_q <= reg_wdata;
    end
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[k] <= CTRL_RST;
      else if (wr && reg_addr == ctrl_addr(k)) ctrl_q[k] <= reg_wdata;
    end
    assign mode_vec[k] = ctrl_q[k][1:0];
    assign ce_vec[k]   = ctrl_q[k][F_CE];
    assign wen_vec[k]  = cfg_q[F_WEN0 + k];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CFG)   reg_rdata = cfg_q;
    if (reg_addr == A_AMODE) reg_rdata = amode_q;
    if (reg_addr == A_STAT)  reg_rdata = STAT_VAL;
    for (int k = 0; k < NUM_CS; k++) begin
      if (reg_addr == ctrl_addr(k)) reg_rdata = ctrl_q[k];
    end
  end
endmodule

// File: rtl/spi_uc_csmux.sv
module spi_uc_csmux #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned CSW    = 2
) (
  input  logic [NUM_CS-1:0][1:0] mode_vec,
  input  logic [NUM_CS-1:0]      ce_vec,
  input  logic [NUM_CS-1:0]      wen_vec,
  input  logic [CSW-1:0]         dp_cs,
  output logic                   sel_user,
  output logic                   sel_wen,
  output logic [NUM_CS-1:0]      cs_n
);
  import spi_uc_pkg::*;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_line
    assign cs_n[k] = ce_vec[k];
  end

  always_comb begin
    sel_user = 1'b0;
    sel_wen  = 1'b0;
    for (int k = 0; k < NUM_CS; k++) begin
      if (dp_cs == CSW'(k)) begin
        sel_user = (mode_vec[k] == MODE_USER);
        sel_wen  = wen_vec[k];
      end
    end
  end
endmodule

// File: rtl/spi_uc_seq.sv
module spi_uc_seq
  import spi_uc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_req,
  input  logic          dp_we,
  input  logic [IW-1:0] dp_size,
  input  logic [DW-1:0] dp_wdata,
  input  logic          sel_user,
  input  logic          sel_wen,
  input  logic          sb_busy,
  input  logic          sb_done,
  input  logic [7:0]    sb_rx,
  output logic          sb_start,
  output logic [7:0]    sb_tx,
  output logic          dp_ready,
  output logic [DW-1:0] dp_rdata,
  output logic          ev_accept,
  output logic          ev_user,
  output logic [IW:0]   ev_nbytes
);
  sq_state_e      st;
  logic           we_q;
  logic [DW-1:0]  wbuf;
  logic [DW-1:0]  rbuf;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  last;

  assign ev_accept = (st == SQ_IDLE) && dp_req;
  assign ev_user   = sel_user && (!dp_we || sel_wen);
  assign ev_nbytes = count_of(dp_size);

  assign sb_start = (st == SQ_ISSUE) && !sb_busy;
  assign sb_tx    = we_q ? byte_of(wbuf, idx) : 8'h00;
  assign dp_ready = (st == SQ_DONE);
  assign dp_rdata = rbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      we_q <= 1'b0;
      wbuf <= '0;
      rbuf <= '0;
      idx  <= '0;
      last <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (dp_req) begin
          we_q <= dp_we;
          wbuf <= dp_wdata;
          last <= dp_size;
          idx  <= '0;
          if (ev_user) begin
            rbuf <= '0;
            st   <= SQ_ISSUE;
          end else begin
            rbuf <= (!dp_we && !sel_user) ? '1 : '0;
            st   <= SQ_DONE;
          end
        end
        SQ_ISSUE: if (!sb_busy) st <= SQ_WAIT;
        SQ_WAIT: if (sb_done) begin
          rbuf <= byte_put(rbuf, idx, sb_rx);
          if (idx == last) st <= SQ_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= SQ_ISSUE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_user_ctrl.sv
module spi_user_ctrl
  import spi_uc_pkg::*;
#(
  parameter int unsigned NUM_CS    = 4,
  parameter bit          STRAP_CS0 = 1'b1,
  localparam int unsigned CSW      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dp_req,
  input  logic              dp_we,
  input  logic [CSW-1:0]    dp_cs,
  input  logic [1:0]        dp_size,
  input  logic [31:0]       dp_wdata,
  output logic [31:0]       dp_rdata,
  output logic              dp_ready,
  output logic              sb_start,
  output logic [7:0]        sb_tx,
  input  logic              sb_busy,
  input  logic              sb_done,
  input  logic [7:0]        sb_rx,
  output logic [NUM_CS-1:0] cs_n
);
  logic [NUM_CS-1:0][1:0] mode_vec;
  logic [NUM_CS-1:0]      ce_vec;
  logic [NUM_CS-1:0]      wen_vec;
  logic                   sel_user;
  logic                   sel_wen;
  logic                   ev_accept;
  logic                   ev_user;
  logic [IW:0]            ev_nbytes;

  spi_uc_regs #(.NUM_CS(NUM_CS), .STRAP_CS0(STRAP_CS0)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mode_vec(mode_vec), .ce_vec(ce_vec), .wen_vec(wen_vec)
  );

  spi_uc_csmux #(.NUM_CS(NUM_CS), .CSW(CSW)) u_csmux (
    .mode_vec(mode_vec), .ce_vec(ce_vec), .wen_vec(wen_vec), .dp_cs(dp_cs),
    .sel_user(sel_user), .sel_wen(sel_wen), .cs_n(cs_n)
  );

  spi_uc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .dp_req(dp_req), .dp_we(dp_we),
    .dp_size(dp_size), .dp_wdata(dp_wdata), .sel_user(sel_user),
    .sel_wen(sel_wen), .sb_busy(sb_busy), .sb_done(sb_done), .sb_rx(sb_rx),
    .sb_start(sb_start), .sb_tx(sb_tx), .dp_ready(dp_ready),
    .dp_rdata(dp_rdata), .ev_accept(ev_accept), .ev_user(ev_user),
    .ev_nbytes(ev_nbytes)
  );
endmodule

// File: rtl/spi_uc_chk.sv
module spi_uc_chk #(
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_we,
  input logic              dp_we,
  input logic              dp_ready,
  input logic [31:0]       dp_rdata,
  input logic              sb_start,
  input logic              sb_busy,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sel_user,
  input logic              ev_accept,
  input logic              ev_user,
  input logic [2:0]        ev_nbytes
);
  logic [3:0] cnt;
  logic       act_user;
  logic [2:0] act_n;
  logic       ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_user <= 1'b0;
      act_n    <= '0;
      ones_q   <= 1'b0;
    end else if (ev_accept) begin
      cnt      <= '0;
      act_user <= ev_user;
      act_n    <= ev_nbytes;
      ones_q   <= !dp_we && !sel_user;
    end else if (sb_start) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_start_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sb_start |-> !sb_busy);
  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sb_start |=> !sb_start);
  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dp_ready |=> !dp_ready);
  assert_cs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && reg_we) |=> $stable(cs_n));
  assert_exchange_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_ready && act_user) |-> (cnt == {1'b0, act_n}));
  assert_no_exchange_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_ready && !act_user) |-> (cnt == 4'd0));
  assert_nonuser_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_ready && ones_q) |-> (dp_rdata == 32'hFFFF_FFFF));
endmodule

bind spi_user_ctrl spi_uc_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .dp_we(dp_we), .dp_ready(dp_ready), .dp_rdata(dp_rdata),
  .sb_start(sb_start), .sb_busy(sb_busy), .cs_n(cs_n),
  .sel_user(sel_user), .ev_accept(ev_accept), .ev_user(ev_user),
  .ev_nbytes(ev_nbytes)
);

// File: tb/spi_user_ctrl_bench.sv
module spi_user_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        dp_req = 1'b0, dp_we = 1'b0;
  logic [1:0]  dp_cs = '0, dp_size = '0;
  logic [31:0] dp_wdata = '0, dp_rdata;
  logic        dp_ready, sb_start;
  logic [7:0]  sb_tx;
  logic        sb_busy = 1'b0, sb_done = 1'b0;
  logic [7:0]  sb_rx = '0;
  logic [3:0]  cs_n;

  int vectors = 0, miscompares = 0, n_starts = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_next = 8'h5A;

  always #5 clk = ~clk;

  spi_user_ctrl u_spi_user_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dp_req(dp_req), .dp_we(dp_we), .dp_cs(dp_cs), .dp_size(dp_size),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_ready(dp_ready),
    .sb_start(sb_start), .sb_tx(sb_tx), .sb_busy(sb_busy),
    .sb_done(sb_done), .sb_rx(sb_rx), .cs_n(cs_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte-engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      sb_done = 1'b0;
      if (sb_start) begin
        n_starts++;
        vectors++;
        if (exp_q.size() == 0) begin
          miscompares++;
          $display("FAIL R8 actual=exchange tx=%h expected=no exchange", sb_tx);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (sb_tx !== e) begin
            miscompares++;
            $display("FAIL R7 actual=%h expected=%h", sb_tx, e);
          end
        end
        @(negedge clk); sb_busy = 1'b1;
        @(negedge clk);
        @(negedge clk); sb_busy = 1'b0; sb_done = 1'b1;
        sb_rx = rx_next;
        rx_next = rx_next + 8'h13;
      end
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic reg_chk(input string req, input logic [7:0] a, input logic [31:0] e);
    logic [31:0] d;
    reg_rd(a, d);
    check(req, d, e);
  endtask

  task automatic dp_go(input logic we, input logic [1:0] cs, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    dp_req = 1'b1; dp_we = we; dp_cs = cs; dp_size = sz; dp_wdata = wd;
    do @(negedge clk); while (!dp_ready);
    rd = dp_rdata;
    dp_req = 1'b0;
    @(negedge clk);
    check("R11", {31'b0, dp_ready}, 32'd0);
  endtask

  // user read: pushes zero bytes, predicts packed reply
  task automatic user_read(input logic [1:0] cs, input logic [1:0] sz);
    logic [31:0] exp, rd;
    logic [7:0] v;
    int s0;
    exp = '0;
    v = rx_next;
    for (int i = 0; i <= int'(sz); i++) begin
      exp_q.push_back(8'h00);
      exp[8*i +: 8] = v;
      v = v + 8'h13;
    end
    s0 = n_starts;
    dp_go(1'b0, cs, sz, 32'h0, rd);
    check("R6 data", rd, exp);
    check("R11 count", n_starts - s0, int'(sz) + 1);
  endtask

  task automatic user_write(input logic [1:0] cs, input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] rd;
    int s0;
    for (int i = 0; i <= int'(sz); i++) exp_q.push_back(wd[8*i +: 8]);
    s0 = n_starts;
    dp_go(1'b1, cs, sz, wd, rd);
    check("R7 count", n_starts - s0, int'(sz) + 1);
  endtask

  task automatic dropped(input string req, input logic we, input logic [1:0] cs,
                         input logic [31:0] exp_rd, input logic chk_rd);
    logic [31:0] rd;
    int s0;
    s0 = n_starts;
    dp_go(we, cs, 2'd3, 32'hDEAD_BEEF, rd);
    check(req, n_starts - s0, 0);
    if (chk_rd) check(req, rd, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 cs_n", {28'b0, cs_n}, 32'hF);
    reg_chk("R1 cfg", 8'h00, 32'h2);
    reg_chk("R1 amode", 8'h04, 32'h1);
    reg_chk("R1 stat", 8'h08, 32'h800);
    for (int k = 0; k < 4; k++) reg_chk("R1 ctrl", 8'(8'h20 + 4 * k), 32'h4);
    // R3 unmapped / read-only
    reg_wr(8'h0C, 32'h1234_5678);
    reg_chk("R3 unmapped", 8'h0C, 32'h0);
    reg_wr(8'h08, 32'h0);
    reg_chk("R3 stat ro", 8'h08, 32'h800);
    reg_wr(8'h21, 32'hFFFF_FFFF);
    reg_chk("R3 unaligned", 8'h21, 32'h0);
    reg_chk("R3 ctrl0 kept", 8'h20, 32'h4);
    reg_chk("R3 cfg kept", 8'h00, 32'h2);
    // R2 storage, R4 select drive, R5 user mode on cs1
    reg_wr(8'h24, 32'h00AB_0003);
    check("R4 cs1 low", {28'b0, cs_n}, 32'hD);
    reg_chk("R2 ctrl1 opcode", 8'h24, 32'h00AB_0003);
    reg_wr(8'h00, 32'h0002_0002);
    reg_chk("R2 cfg", 8'h00, 32'h0002_0002);
    reg_wr(8'h04, 32'h0000_0003);
    reg_chk("R2 amode", 8'h04, 32'h3);
    // R6 user reads
    user_read(2'd1, 2'd3);
    user_read(2'd1, 2'd0);
    user_read(2'd1, 2'd1);
    // R7 user writes
    user_write(2'd1, 2'd2, 32'h00C0_FFEE);
    user_write(2'd1, 2'd3, 32'h8765_4321);
    check("R7 queue drained", exp_q.size(), 0);
    // R8 write without permission on cs2
    reg_wr(8'h28, 32'h0000_0003);
    check("R4 cs2 low", {28'b0, cs_n}, 32'h9);
    dropped("R8 write dropped", 1'b1, 2'd2, 32'h0, 1'b0);
    user_read(2'd2, 2'd1);
    // R9 non-user modes on cs0
    dropped("R9 normal read", 1'b0, 2'd0, 32'hFFFF_FFFF, 1'b1);
    reg_wr(8'h20, 32'h0000_0005);
    dropped("R9 fast read", 1'b0, 2'd0, 32'hFFFF_FFFF, 1'b1);
    reg_wr(8'h00, 32'h0003_0002);
    reg_wr(8'h20, 32'h0000_0006);
    dropped("R9 write mode", 1'b1, 2'd0, 32'h0, 1'b0);
    // R4 deselect again
    reg_wr(8'h24, 32'h00AB_0007);
    check("R4 cs1 high", {28'b0, cs_n}, 32'hB);
    check("R10 all exchanges consumed", exp_q.size(), 0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule